// File: doc/BRIEF.md
# Triple Interval Counter with Command Decoder

Three 16-bit down-counters share one byte-wide register port. A control byte written to the command slot picks a counter. It then either programs that counter's operating mode or asks it to freeze a snapshot of its count so that software can read a consistent value. Each counter's start value arrives in two byte writes to the counter's own slot, low byte first. A count is consumed on each cycle in which the tick-enable input is high. That input stands in for a slow reference clock, so the whole block runs from the system clock.

Three modes are supported. In single-shot mode the output rises on terminal count and stays high. In rate mode the output drops low for one tick per period. In square mode the output toggles every half period. Counter 2's output can also be read as a bit of a status byte. The block accepts only binary counting with low-then-high byte access. Any other command raises an error pulse and is discarded.

Top module: `tick_timer_trio`

## Requirements
- R1: After reset all three outputs are 0, cmd_err is 0 and rd_data is 0. No counter runs until it has been given a count.
- R2: The control byte is laid out as {channel[7:6], access[5:4], mode[3:1], bcd[0]}. Access 3 with bcd 0 and mode 0, 2 or 3 programs the channel's mode. It stops that channel and sets its output to 0 for mode 0 and to 1 for modes 2 and 3.
- R3: cmd_err goes high for exactly the cycle after a control write with channel 3, access 1 or 2, or access 3 with bcd set or a mode other than 0, 2 or 3. Such a write changes no channel.
- R4: A write to a channel's data slot alternates between low byte and high byte. The low byte stops that channel without changing its count. The high byte loads {high, low} and starts counting, and sets the output to 0 in mode 0 and to 1 otherwise.
- R5: Mode 0: each tick decrements the count. The output goes high on the tick that makes the count 0 and then stays high.
- R6: Mode 2 with a value N≥2: the output is low only while the count is 1. The tick after that reloads N and raises the output.
- R7: Mode 3 with an even value N: the count falls by 2 per tick. The output toggles and N is reloaded on the tick taken at count 2, so each half period is N/2 ticks.
- R8: Reads of a channel slot with no snapshot held return the live count, alternating low byte then high byte.
- R9: A control byte with access 0 captures the channel's count as a snapshot. While a snapshot is held, further captures are ignored and reads return the snapshot. Reading its high byte releases it.
- R10: A read of slot 3 returns a status byte whose bit 5 is counter 2's output and whose other bits are 0.
- R11: Counts change only on cycles with tick_en high.
- R12: rd_data takes the value for a read on the clock edge at which rd_en is sampled, and holds it while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count strobe |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write slot: 0..2 counter data, 3 control byte |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Read slot: 0..2 counter data, 3 status |
| rd_data | output | 8 | Registered read byte |
| chan_out | output | 3 | Per-counter output level |
| cmd_err | output | 1 | One-cycle flag for an unsupported command |

## Verification
Each mode is run on its own counter with a small value, and the output is compared after every single tick. This shows whether the terminal-count edge lands on the right tick: sticky high in mode 0, a one-tick low in mode 2 and half-period toggling in mode 3. A counter kept running with a large value is snapshotted, counted further and then snapshotted again. Reading back snapshot and live bytes shows whether the capture happened, whether the second capture was ignored, and whether the snapshot was released. A low byte written mid-count followed by idle ticks shows the halt. Each kind of illegal control byte is sent while a counter runs, which shows both the error pulse and that the running configuration is left untouched.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [2:0] MD_ONESHOT = 3'd0;
    localparam logic [2:0] MD_RATE    = 3'd2;
    localparam logic [2:0] MD_SQUARE  = 3'd3;

    localparam logic [1:0] ACC_SNAP  = 2'd0;
    localparam logic [1:0] ACC_WORD  = 2'd3;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  snap;
        logic [BYTE_W-1:0] low_stage;
        logic [2:0]        mode;
        logic              running;
        logic              out;
        logic              wr_hi;
        logic              rd_hi;
        logic              snap_held;
    } chan_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] rd_data;
        logic              err;
    } top_state_t;
endpackage

// File: rtl/tick_timer_cmd_dec.sv
module tick_timer_cmd_dec
    import tick_timer_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              ctrl_stb,
    input  logic [7:0]        ctrl_byte,
    output logic [NUM_CH-1:0] prog_vec,
    output logic [NUM_CH-1:0] snap_vec,
    output logic [2:0]        prog_mode,
    output logic              bad_cmd
);
    logic [1:0] f_chan;
    logic [1:0] f_acc;
    logic [2:0] f_mode;
    logic       f_bcd;
    logic       mode_ok;

    always_comb begin
        f_chan    = ctrl_byte[7:6];
        f_acc     = ctrl_byte[5:4];
        f_mode    = ctrl_byte[3:1];
        f_bcd     = ctrl_byte[0];
        mode_ok   = (f_mode == MD_ONESHOT) || (f_mode == MD_RATE) || (f_mode == MD_SQUARE);
        prog_mode = f_mode;
        bad_cmd   = ctrl_stb && ((f_chan == 2'd3) || (32'(f_chan) >= NUM_CH)
                    || (f_acc == 2'd1) || (f_acc == 2'd2)
                    || ((f_acc == ACC_WORD) && (!mode_ok || f_bcd)));
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        always_comb begin
            prog_vec[i] = ctrl_stb && !bad_cmd && (f_acc == ACC_WORD) && (32'(f_chan) == i);
            snap_vec[i] = ctrl_stb && !bad_cmd && (f_acc == ACC_SNAP) && (32'(f_chan) == i);
        end
    end
endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              prog_stb,
    input  logic [2:0]        prog_mode,
    input  logic              snap_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              out
);
    chan_state_t s_q, s_d;
    logic [CNT_W-1:0] src;
    logic [CNT_W-1:0] loaded;

    always_comb begin
        s_d    = s_q;
        loaded = {wr_byte, s_q.low_stage};
        if (prog_stb) begin
            s_d.mode      = prog_mode;
            s_d.running   = 1'b0;
            s_d.wr_hi     = 1'b0;
            s_d.rd_hi     = 1'b0;
            s_d.snap_held = 1'b0;
            s_d.out       = (prog_mode != MD_ONESHOT);
        end else begin
            if (wr_stb) begin
                if (!s_q.wr_hi) begin
                    s_d.low_stage = wr_byte;
                    s_d.running   = 1'b0;
                    s_d.wr_hi     = 1'b1;
                end else begin
                    s_d.reload  = loaded;
                    s_d.count   = (s_q.mode == MD_SQUARE) ? (loaded & 16'hFFFE) : loaded;
                    s_d.running = 1'b1;
                    s_d.wr_hi   = 1'b0;
                    s_d.out     = (s_q.mode != MD_ONESHOT);
                end
            end else if (s_q.running && tick_en) begin
                case (s_q.mode)
                    MD_RATE: begin
                        if (s_q.count == 16'd1) begin
                            s_d.count = s_q.reload;
                            s_d.out   = 1'b1;
                        end else begin
                            s_d.count = s_q.count - 16'd1;
                            s_d.out   = (s_q.count != 16'd2);
                        end
                    end
                    MD_SQUARE: begin
                        if (s_q.count == 16'd2) begin
                            s_d.count = s_q.reload & 16'hFFFE;
                            s_d.out   = ~s_q.out;
                        end else begin
                            s_d.count = s_q.count - 16'd2;
                        end
                    end
                    default: begin
                        s_d.count = s_q.count - 16'd1;
                        if (s_q.count == 16'd1) s_d.out = 1'b1;
                    end
                endcase
            end
            if (snap_stb && !s_q.snap_held) begin
                s_d.snap      = s_q.count;
                s_d.snap_held = 1'b1;
            end
            if (rd_stb) begin
                if (s_q.rd_hi) begin
                    s_d.rd_hi = 1'b0;
                    if (s_q.snap_held) s_d.snap_held = 1'b0;
                end else begin
                    s_d.rd_hi = 1'b1;
                end
            end
        end
    end

    always_comb begin
        src     = s_q.snap_held ? s_q.snap : s_q.count;
        rd_byte = s_q.rd_hi ? src[15:8] : src[7:0];
        out     = s_q.out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tick_timer_trio.sv
module tick_timer_trio
    import tick_timer_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int STAT_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [7:0]       rd_data,
    output logic [NUM_CH-1:0] chan_out,
    output logic             cmd_err
);
    localparam logic [1:0] CTRL_SLOT = 2'd3;
    localparam int         STAT_CH   = NUM_CH - 1;

    top_state_t t_q, t_d;
    logic              ctrl_stb;
    logic [NUM_CH-1:0] prog_vec;
    logic [NUM_CH-1:0] snap_vec;
    logic [2:0]        prog_mode;
    logic              bad_cmd;
    logic [7:0]        byte_arr [NUM_CH];
    logic [7:0]        status_byte;
    logic [7:0]        sel_byte;

    assign ctrl_stb = wr_en && (wr_sel == CTRL_SLOT);

    tick_timer_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
        .ctrl_stb (ctrl_stb),
        .ctrl_byte(wr_data),
        .prog_vec (prog_vec),
        .snap_vec (snap_vec),
        .prog_mode(prog_mode),
        .bad_cmd  (bad_cmd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tick_timer_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .prog_stb (prog_vec[i]),
            .prog_mode(prog_mode),
            .snap_stb (snap_vec[i]),
            .wr_stb   (wr_en && (32'(wr_sel) == i)),
            .wr_byte  (wr_data),
            .rd_stb   (rd_en && (32'(rd_sel) == i)),
            .rd_byte  (byte_arr[i]),
            .out      (chan_out[i])
        );
    end

    always_comb begin
        status_byte           = '0;
        status_byte[STAT_BIT] = chan_out[STAT_CH];
        sel_byte              = status_byte;
        for (int i = 0; i < NUM_CH; i++) begin
            if (32'(rd_sel) == i) sel_byte = byte_arr[i];
        end
        t_d         = t_q;
        t_d.err     = bad_cmd;
        if (rd_en) t_d.rd_data = sel_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rd_data = t_q.rd_data;
    assign cmd_err = t_q.err;
endmodule

// File: rtl/tick_timer_trio_chk.sv
module tick_timer_trio_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [1:0] rd_sel,
    input logic [7:0] rd_data,
    input logic [2:0] chan_out,
    input logic       cmd_err
);
    AST_ERR_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'd3) |=> !cmd_err); // R3
    AST_SEL3_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && wr_data[7:6] == 2'd3) |=> cmd_err); // R3
    AST_STATUS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd3) |=> (rd_data == {2'b00, $past(chan_out[2]), 5'b0})); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R12
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(chan_out)); // R11
endmodule

bind tick_timer_trio tick_timer_trio_chk u_chk (.*);

// File: tb/sim_tick_timer_trio.sv
`timescale 1ns/1ps
module sim_tick_timer_trio;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic [2:0] chan_out;
    logic       cmd_err;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    tick_timer_trio u0 (.*);

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [7:0] v);
        rd_en = 1'b1; rd_sel = s;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic ticks(int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 out", chan_out, 0);
        chk("R1 err", cmd_err, 0);
        chk("R1 rd", rd_data, 0);
        ticks(3);
        rd(2'd0, v); chk("R1 idle count lo", v, 0);
        rd(2'd0, v); chk("R1 idle count hi", v, 0);
    endtask

    task automatic t_mode0;
        wr(2'd3, 8'h30);
        chk("R2 mode0 out low", chan_out[0], 0);
        wr(2'd0, 8'h05); wr(2'd0, 8'h00);
        for (int i = 1; i <= 5; i++) begin
            ticks(1);
            chk("R5 mode0 out", chan_out[0], (i == 5) ? 1 : 0);
        end
        ticks(4);
        chk("R5 mode0 stays high", chan_out[0], 1);
    endtask

    task automatic t_mode2;
        wr(2'd3, 8'h74);
        chk("R2 mode2 out high", chan_out[1], 1);
        wr(2'd1, 8'h04); wr(2'd1, 8'h00);
        for (int i = 1; i <= 8; i++) begin
            ticks(1);
            chk("R6 mode2 out", chan_out[1], (i == 3 || i == 7) ? 0 : 1);
        end
    endtask

    task automatic t_mode3;
        logic [7:0] v;
        wr(2'd3, 8'hB6);
        wr(2'd2, 8'h06); wr(2'd2, 8'h00);
        for (int i = 1; i <= 9; i++) begin
            ticks(1);
            chk("R7 mode3 out", chan_out[2], ((i / 3) % 2 == 1) ? 0 : 1);
        end
        rd(2'd3, v); chk("R10 status ch2 low", v, 8'h00);
        ticks(3);
        rd(2'd3, v); chk("R10 status ch2 high", v, 8'h20);
    endtask

    task automatic t_snap;
        logic [7:0] v;
        wr(2'd3, 8'h74);
        wr(2'd1, 8'h34); wr(2'd1, 8'h12);
        ticks(4);
        wr(2'd3, 8'h40);
        ticks(3);
        wr(2'd3, 8'h40);
        rd(2'd1, v); chk("R9 snap lo", v, 8'h30);
        rd(2'd1, v); chk("R9 snap hi", v, 8'h12);
        rd(2'd1, v); chk("R8 live lo", v, 8'h2D);
        repeat (2) @(negedge clk);
        chk("R12 hold", rd_data, 8'h2D);
        rd(2'd1, v); chk("R8 live hi", v, 8'h12);
        // malformed commands while ch1 runs: no effect on its mode or count
        wr(2'd3, 8'hC0); chk("R3 sel3", cmd_err, 1);
        @(negedge clk); chk("R3 one cycle", cmd_err, 0);
        wr(2'd3, 8'h50); chk("R3 access1", cmd_err, 1);
        wr(2'd3, 8'h62); chk("R3 access2", cmd_err, 1);
        wr(2'd3, 8'h72); chk("R3 mode1", cmd_err, 1);
        wr(2'd3, 8'h75); chk("R3 bcd", cmd_err, 1);
        ticks(2);
        rd(2'd1, v); chk("R3 ch1 still counting lo", v, 8'h2B);
        rd(2'd1, v); chk("R3 ch1 hi", v, 8'h12);
        chk("R3 ch1 out", chan_out[1], 1);
    endtask

    task automatic t_halt;
        logic [7:0] v;
        wr(2'd3, 8'h30);
        chk("R2 valid no err", cmd_err, 0);
        wr(2'd0, 8'h0A); wr(2'd0, 8'h00);
        ticks(3);
        wr(2'd0, 8'h20);
        ticks(5);
        rd(2'd0, v); chk("R4 halted lo", v, 8'h07);
        rd(2'd0, v); chk("R4 halted hi", v, 8'h00);
        wr(2'd0, 8'h01);
        ticks(2);
        rd(2'd0, v); chk("R4 reload lo", v, 8'h1E);
        rd(2'd0, v); chk("R4 reload hi", v, 8'h01);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R11 no tick lo", v, 8'h1E);
        rd(2'd0, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode2();
        t_mode3();
        t_snap();
        t_halt();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule